// File: doc/BRIEF.md
# Dual-Direction Byte FIFO With Threshold Flags

This block is a 16-byte buffer that sits between a processor and a card data line. It carries traffic one way at a time. A direction input selects the mode. In receive mode the line side fills the buffer and the processor drains it. In transmit mode the processor fills it and the line side drains it. Storage is tracked by a single fill pointer that software cannot see. New bytes land at the pointer position, and a read takes the oldest byte and shifts the rest down one place.

Two live status flags report whether the whole buffer or at least half of it can be serviced by software. In receive mode that means bytes waiting to be read. In transmit mode it means free slots to be written. Two sticky event flags record each upward crossing of those thresholds and clear when software reads them. Each event flag has its own enable, and the enabled flags are combined into one interrupt line.

A pointer-reset input abandons the transfer in progress at any moment. Holding it high and then releasing it leaves the buffer empty.

Top module: `dualdir_byte_fifo`

## Requirements
- R1: After reset the buffer holds 0 bytes. Both event flags and `irq` are 0. With `dir_tx`=0 both status flags are 0.
- R2: Bytes leave in the order they were accepted. `cpu_rdata` and `line_rdata` both show the oldest held byte from the rising edge that accepts a write into an empty buffer or accepts a read.
- R3: With `dir_tx`=0 only `line_wr` writes and only `cpu_rd` reads. With `dir_tx`=1 only `cpu_wr` writes and only `line_rd` reads. The other two strobes have no effect.
- R4: A write while 16 bytes are held is ignored, even if a read is accepted in the same cycle. A read while 0 bytes are held is ignored. The held count never exceeds 16.
- R5: The serviceable count is the held count when `dir_tx`=0, and 16 minus the held count when `dir_tx`=1. `sts_full` is 1 exactly when that count equals 16. `sts_half` is 1 exactly when it is at least 8. Both follow the state with no extra register stage.
- R6: While `ptr_rst` is 1, every write and read strobe is ignored and the status flags are computed as if the buffer were empty. After `ptr_rst` has been high for one rising edge, the held count is 0.
- R7: An event flag becomes 1 at the rising edge after its status flag goes from 0 to 1. It fires once per crossing, so it is not raised again until the status has dropped to 0 and risen again. No crossing is detected at the first edge after reset.
- R8: A `stat_rd` pulse clears both event flags at the next rising edge. A crossing detected at that same edge sets its flag anyway.
- R9: `irq` equals (`evt_full` AND `en_full`) OR (`evt_half` AND `en_half`), without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_tx | input | 1 | 1 = transmit (processor fills), 0 = receive (line fills) |
| ptr_rst | input | 1 | Pointer clear; aborts the transfer while high |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | 8 | Oldest held byte, processor side |
| line_wr | input | 1 | Line-side write strobe |
| line_wdata | input | 8 | Line-side write byte |
| line_rd | input | 1 | Line-side read strobe |
| line_rdata | output | 8 | Oldest held byte, line side |
| stat_rd | input | 1 | Status read pulse; clears the event flags |
| en_full | input | 1 | Interrupt enable for the full event |
| en_half | input | 1 | Interrupt enable for the half event |
| sts_full | output | 1 | Live: 16 bytes serviceable |
| sts_half | output | 1 | Live: at least 8 bytes serviceable |
| evt_full | output | 1 | Sticky full-crossing event |
| evt_half | output | 1 | Sticky half-crossing event |
| irq | output | 1 | Interrupt request |

## Verification
Held data, `sts_full` and `sts_half` are due at the first rising edge after a strobe. The event flags and `irq` follow one rising edge after the status change, and a `stat_rd` clear lands on the edge that samples it. The bench drives every input on a falling edge and lets exactly one rising edge pass. It samples on the next falling edge. Its model applies the same one-edge rule, so the event delay falls out of the previous-status term it keeps rather than from extra waiting. Fill and drain sweeps cover every level from 0 to 16 in both directions, including overflow and underflow attempts, a threshold re-crossing, a clear that collides with a rise, and pointer resets in both modes.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int unsigned FLAG_HALF = 0;
  localparam int unsigned FLAG_FULL = 1;
  localparam int unsigned NFLAG     = 2;

  // Bytes software may service: held bytes when receiving, free slots when transmitting.
  function automatic int unsigned serviceable(input int unsigned held, input logic tx,
                                              input int unsigned depth);
    return tx ? (depth - held) : held;
  endfunction

  // Threshold test for one flag.
  function automatic logic meets(input int unsigned avail, input int unsigned thresh);
    return avail >= thresh;
  endfunction
endpackage

// File: rtl/dbf_store.sv
module dbf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     up  [DEPTH];
  logic             push_ok;
  logic             pop_ok;
  logic [LVL_W-1:0] wr_idx;

  assign pop_ok  = pop  && !clr && (level != '0);
  assign push_ok = push && !clr && (level != LVL_W'(DEPTH));
  assign wr_idx  = pop_ok ? (level - LVL_W'(1)) : level;
  assign head    = mem[0];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_up
    if (gi < DEPTH - 1) begin : g_mid
      assign up[gi] = mem[gi + 1];
    end else begin : g_top
      assign up[gi] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_ok && wr_idx == LVL_W'(i)) mem[i] <= din;
        else if (pop_ok)                    mem[i] <= up[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 level <= '0;
    else if (clr)               level <= '0;
    else if (push_ok && !pop_ok) level <= level + LVL_W'(1);
    else if (pop_ok && !push_ok) level <= level - LVL_W'(1);
  end
endmodule

// File: rtl/dbf_ready.sv
module dbf_ready
  import dbf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic             dir_tx,
  input  logic             hold,
  input  logic [LVL_W-1:0] level,
  output logic [NFLAG-1:0] sts
);
  logic [LVL_W-1:0] eff_level;
  int unsigned      avail;

  assign eff_level = hold ? '0 : level;
  assign avail     = serviceable(32'(eff_level), dir_tx, DEPTH);

  always_comb begin
    sts            = '0;
    sts[FLAG_FULL] = meets(avail, DEPTH);
    sts[FLAG_HALF] = meets(avail, HALF);
  end
endmodule

// File: rtl/dbf_events.sv
module dbf_events #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sts,
  input  logic         rd_clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] evt,
  output logic         irq
);
  logic [N-1:0] sts_q;
  logic [N-1:0] rise;

  assign rise = sts & ~sts_q;
  assign irq  = |(evt & en);

  // sts_q starts at all ones so that no crossing is seen at the first edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '1;
      evt   <= '0;
    end else begin
      sts_q <= sts;
      evt   <= rise | (evt & {N{~rd_clr}});
    end
  end
endmodule

// File: rtl/dualdir_byte_fifo.sv
module dualdir_byte_fifo
  import dbf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_tx,
  input  logic         ptr_rst,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_rd,
  output logic [W-1:0] cpu_rdata,
  input  logic         line_wr,
  input  logic [W-1:0] line_wdata,
  input  logic         line_rd,
  output logic [W-1:0] line_rdata,
  input  logic         stat_rd,
  input  logic         en_full,
  input  logic         en_half,
  output logic         sts_full,
  output logic         sts_half,
  output logic         evt_full,
  output logic         evt_half,
  output logic         irq
);
  // Named internal events, visible to the bound checker.
  logic             prod_wr;
  logic [W-1:0]     prod_data;
  logic             cons_rd;
  logic [W-1:0]     head;
  logic [LVL_W-1:0] level;
  logic [NFLAG-1:0] sts;
  logic [NFLAG-1:0] evt;
  logic [NFLAG-1:0] en;

  assign prod_wr   = dir_tx ? cpu_wr    : line_wr;
  assign prod_data = dir_tx ? cpu_wdata : line_wdata;
  assign cons_rd   = dir_tx ? line_rd   : cpu_rd;

  dbf_store #(.DEPTH(DEPTH), .W(W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ptr_rst),
    .push  (prod_wr),
    .din   (prod_data),
    .pop   (cons_rd),
    .head  (head),
    .level (level)
  );

  dbf_ready #(.DEPTH(DEPTH)) ready_i (
    .dir_tx (dir_tx),
    .hold   (ptr_rst),
    .level  (level),
    .sts    (sts)
  );

  always_comb begin
    en            = '0;
    en[FLAG_FULL] = en_full;
    en[FLAG_HALF] = en_half;
  end

  dbf_events #(.N(NFLAG)) events_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sts    (sts),
    .rd_clr (stat_rd),
    .en     (en),
    .evt    (evt),
    .irq    (irq)
  );

  assign cpu_rdata  = head;
  assign line_rdata = head;
  assign sts_full   = sts[FLAG_FULL];
  assign sts_half   = sts[FLAG_HALF];
  assign evt_full   = evt[FLAG_FULL];
  assign evt_half   = evt[FLAG_HALF];
endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_tx,
  input logic             ptr_rst,
  input logic             cons_rd,
  input logic             stat_rd,
  input logic [LVL_W-1:0] level,
  input logic             sts_full,
  input logic             sts_half,
  input logic             evt_full,
  input logic             evt_half
);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH) && !cons_rd && !ptr_rst) |=> (level == LVL_W'(DEPTH)));

  a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    sts_full |-> sts_half);

  a_r6_pointer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (level == '0));

  a_r6_rx_empty_view: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rst && !dir_tx) |-> (!sts_half && !sts_full));

  a_r7_full_event: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_full) && $past(rst_n)) |=> evt_full);

  a_r7_half_event: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_half) && $past(rst_n)) |=> evt_half);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $stable(sts_full) && $stable(sts_half) && $past(rst_n))
      |=> (!evt_full && !evt_half));
endmodule

bind dualdir_byte_fifo dbf_checker #(.DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_tx   (dir_tx),
  .ptr_rst  (ptr_rst),
  .cons_rd  (cons_rd),
  .stat_rd  (stat_rd),
  .level    (level),
  .sts_full (sts_full),
  .sts_half (sts_half),
  .evt_full (evt_full),
  .evt_half (evt_half)
);

// File: tb/dualdir_byte_fifo_tb.sv
module dualdir_byte_fifo_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_tx = 1'b0, ptr_rst = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, line_wr = 1'b0, line_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, line_wdata = '0;
  logic       stat_rd = 1'b0, en_full = 1'b0, en_half = 1'b0;
  logic [7:0] cpu_rdata, line_rdata;
  logic       sts_full, sts_half, evt_full, evt_half, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model state
  int         m_lev = 0;
  logic [7:0] m_q [DEPTH];
  bit         m_evf = 0, m_evh = 0, m_qf = 1, m_qh = 1;

  always #2 clk = ~clk;

  dualdir_byte_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .ptr_rst(ptr_rst),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .line_wr(line_wr), .line_wdata(line_wdata), .line_rd(line_rd), .line_rdata(line_rdata),
    .stat_rd(stat_rd), .en_full(en_full), .en_half(en_half),
    .sts_full(sts_full), .sts_half(sts_half), .evt_full(evt_full), .evt_half(evt_half),
    .irq(irq)
  );

  function automatic int m_avail();
    int eff;
    eff = ptr_rst ? 0 : m_lev;
    return dir_tx ? (DEPTH - eff) : eff;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int av;
    bit sf, sh;
    av = m_avail();
    sf = (av == DEPTH);
    sh = (av >= DEPTH / 2);
    chk(tag, "sts_full", int'(sts_full), int'(sf));
    chk(tag, "sts_half", int'(sts_half), int'(sh));
    chk(tag, "evt_full", int'(evt_full), int'(m_evf));
    chk(tag, "evt_half", int'(evt_half), int'(m_evh));
    chk(tag, "irq", int'(irq), int'((m_evf && en_full) || (m_evh && en_half)));
    if (m_lev > 0) begin
      chk(tag, "cpu_rdata", int'(cpu_rdata), int'(m_q[0]));
      chk(tag, "line_rdata", int'(line_rdata), int'(m_q[0]));
    end
  endtask

  // Advance one rising edge with the current inputs; update the model; clear strobes.
  task automatic tick();
    int av;
    bit sf, sh, prod, cons, push_ok, pop_ok;
    logic [7:0] pd;
    av = m_avail();
    sf = (av == DEPTH);
    sh = (av >= DEPTH / 2);
    m_evf = (m_evf && !stat_rd) || (sf && !m_qf);
    m_evh = (m_evh && !stat_rd) || (sh && !m_qh);
    m_qf = sf;
    m_qh = sh;
    if (ptr_rst) begin
      m_lev = 0;
    end else begin
      prod    = dir_tx ? cpu_wr : line_wr;
      pd      = dir_tx ? cpu_wdata : line_wdata;
      cons    = dir_tx ? line_rd : cpu_rd;
      push_ok = prod && (m_lev < DEPTH);
      pop_ok  = cons && (m_lev > 0);
      if (pop_ok) begin
        for (int k = 0; k < DEPTH - 1; k++) m_q[k] = m_q[k + 1];
        m_lev--;
      end
      if (push_ok) begin
        m_q[m_lev] = pd;
        m_lev++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; line_wr = 0; line_rd = 0; stat_rd = 0;
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) m_q[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // Receive fill, with processor writes that must be ignored
    dir_tx = 0;
    for (int i = 0; i <= DEPTH; i++) begin
      line_wr = 1; line_wdata = 8'h30 + 8'(i);
      cpu_wr = 1;  cpu_wdata = 8'hEE;
      tick();
      check_all(i == DEPTH ? "R4" : (i >= 7 ? "R7" : "R3"));
    end
    tick(); check_all("R7");
    en_full = 1; en_half = 0; tick(); check_all("R9");
    en_full = 0; en_half = 1; tick(); check_all("R9");
    stat_rd = 1; tick(); check_all("R8");
    tick(); check_all("R8");
    // Receive drain; the extra read hits an empty buffer
    for (int i = 0; i <= DEPTH; i++) begin
      cpu_rd = 1; line_rd = (i % 2 == 0);
      tick();
      check_all(i == DEPTH ? "R4" : "R2");
    end

    // Transmit: empty buffer is fully serviceable
    dir_tx = 1; tick(); check_all("R5");
    tick(); check_all("R7");
    stat_rd = 1; tick(); check_all("R8");
    for (int i = 0; i <= DEPTH; i++) begin
      cpu_wr = 1; cpu_wdata = 8'hA0 ^ 8'(i * 7);
      line_wr = 1; line_wdata = 8'h55;
      tick();
      check_all(i == DEPTH ? "R4" : "R5");
    end
    // Read and write together while full: write dropped, read taken
    line_rd = 1; cpu_wr = 1; cpu_wdata = 8'h99; tick(); check_all("R4");
    for (int i = 0; i <= DEPTH; i++) begin
      line_rd = 1; cpu_rd = 1;
      tick();
      check_all(i >= DEPTH - 1 ? "R4" : "R2");
    end
    stat_rd = 1; tick(); check_all("R8");
    // Re-crossing of the half threshold, with a clear colliding with the rise
    for (int i = 0; i < 9; i++) begin
      cpu_wr = 1; cpu_wdata = 8'(i + 1); tick(); check_all("R7");
    end
    line_rd = 1; tick(); check_all("R7");
    stat_rd = 1; tick(); check_all("R8");
    tick(); check_all("R7");

    // Pointer reset in transmit mode with strobes active
    ptr_rst = 1;
    for (int i = 0; i < 3; i++) begin
      cpu_wr = 1; cpu_wdata = 8'h77; line_rd = 1; tick(); check_all("R6");
    end
    ptr_rst = 0; tick(); check_all("R6");
    // Pointer reset in receive mode
    dir_tx = 0; tick(); check_all("R5");
    for (int i = 0; i < 10; i++) begin
      line_wr = 1; line_wdata = 8'hC0 + 8'(i); tick(); check_all("R3");
    end
    ptr_rst = 1; line_wr = 1; line_wdata = 8'h11; cpu_rd = 1; tick(); check_all("R6");
    tick(); check_all("R6");
    ptr_rst = 0; tick(); check_all("R6");
    line_wr = 1; line_wdata = 8'h5A; tick(); check_all("R2");

    // Interrupt enable sweep with both events raised
    dir_tx = 1; tick(); tick();
    for (int e = 0; e < 4; e++) begin
      en_full = e[0]; en_half = e[1];
      #1; check_all("R9");
    end
    stat_rd = 1; tick(); check_all("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule